// File: doc/BRIEF.md
# Hold-State Power Controller with Timed Restart

This block decides when a small processor core drops into its deepest low-power state, in which the main oscillator is switched off. It also brings the core back out of that state. The core asks for the hold state with a one-cycle strobe. The request takes effect only when the external hold pin is low. If the pin is high, the request is treated as a no-op. While held, the oscillator enable and the CPU clock enable are both low. Raising the hold pin wakes the block. Waking turns the oscillator back on and starts a fixed stabilisation wait of 2^WAIT_W cycles (16384 by default). When the wait ends, the CPU clock is enabled and a one-cycle strobe tells the timer to load its preset.

The external reset pin is qualified by the hold pin. A low reset level is acted on only while the synchronised hold pin is high, and only after it has been seen low for RST_FILT consecutive cycles. An accepted reset asserts the internal core reset and abandons any wait in progress. After the reset pin is released, the same full stabilisation wait runs again before the core is released. The system reset of the block behaves like an accepted reset.

The controller clock is assumed to keep running while the oscillator enable is low. In practice this is a small always-on clock. Both pins pass through SYNC_STAGES-deep synchronisers before any use.

Top module: `hold_wake_ctrl`

## Requirements
- R1: During and after system reset `rst`, `core_rst`=1, `osc_en`=1 and `cpu_clk_en`=0. Counting from the first clock edge with `rst` low, `cpu_clk_en` goes to 1 and `core_rst` to 0 at edge 2^WAIT_W.
- R2: A `hold_req` strobe while the synchronised hold pin is low and the CPU runs enters hold at that edge: `osc_en`=0 and `cpu_clk_en`=0 until wake.
- R3: A `hold_req` strobe while the synchronised hold pin is high has no effect: `osc_en` and `cpu_clk_en` stay 1.
- R4: In hold, driving `hold_pin` high sets `osc_en` to 1 at the third clock edge after the change (two synchroniser flops, one state register).
- R5: After `osc_en` rises on wake, `cpu_clk_en` stays 0 for exactly 2^WAIT_W cycles, then rises.
- R6: `tmr_preset` is a single-cycle pulse, high exactly in the cycle in which `cpu_clk_en` rises, after both wake and reset.
- R7: While the hold pin is low, a low `rst_pin_n` of any length is ignored: `core_rst` stays 0 and the clock enables keep their values.
- R8: With the hold pin high, a low `rst_pin_n` shorter than RST_FILT (3) cycles is ignored. A low of L≥3 cycles, driven after edge k, raises `core_rst` at edge k+6 and releases the core at edge k+L+3+2^WAIT_W.
- R9: An accepted reset during the stabilisation wait abandons that wait. `cpu_clk_en` stays 0 and the full wait restarts after the reset pin is released.
- R10: Waking from hold never asserts `core_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high system reset |
| hold_req | input | 1 | One-cycle hold request strobe from the CPU |
| hold_pin | input | 1 | Asynchronous hold pin; low permits hold, high wakes and permits reset |
| rst_pin_n | input | 1 | Asynchronous active-low external reset pin |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| core_rst | output | 1 | Internal core reset, active high |
| tmr_preset | output | 1 | One-cycle strobe to load the timer preset |

## Verification
The assertions assume `hold_req` is only strobed while the CPU clock runs. They assume the hold pin is not raised at the same moment a qualified reset completes inside the hold state. The bench keeps to both: it issues requests only in the run state, and it returns the reset pin high well before each wake. It also waits at least RST_FILT+3 cycles between pin edges, so that each synchroniser settles before the next stimulus. Reset-pin pulse lengths and reset offsets within the wait are swept over small ranges against a reduced WAIT_W.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_HOLD = 2'd1,
    PS_STAB = 2'd2
  } pstate_t;
endpackage

// File: rtl/hwc_sync.sv
module hwc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        chain[i] <= RST_VAL;
      end else begin
        if (i == 0) chain[i] <= din;
        else        chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hwc_rst_filter.sv
module hwc_rst_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_n,
  output logic held_low
);
  localparam int CW = $clog2(FILT + 1);
  localparam logic [CW-1:0] TOP = CW'(FILT);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || lvl_n) begin
      run_len <= '0;
    end else if (run_len != TOP) begin
      run_len <= run_len + 1'b1;
    end
  end

  assign held_low = (run_len == TOP);
endmodule

// File: rtl/hwc_stab_cnt.sv
module hwc_stab_cnt #(
  parameter int W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic last
);
  logic [W-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ticks <= '0;
    end else if (en) begin
      ticks <= ticks + 1'b1;
    end
  end

  assign last = &ticks;
endmodule

// File: rtl/hold_wake_ctrl.sv
module hold_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int WAIT_W      = 14,
  parameter int SYNC_STAGES = 2,
  parameter int RST_FILT    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  input  logic hold_pin,
  input  logic rst_pin_n,
  output logic osc_en,
  output logic cpu_clk_en,
  output logic core_rst,
  output logic tmr_preset
);
  pstate_t state;
  logic    hold_s;
  logic    rstn_s;
  logic    rst_low;
  logic    rst_take;
  logic    wait_done;
  logic    wake;
  logic    cnt_clr;

  hwc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_sync (
    .clk(clk), .rst(rst), .din(hold_pin), .dout(hold_s)
  );

  hwc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .clk(clk), .rst(rst), .din(rst_pin_n), .dout(rstn_s)
  );

  hwc_rst_filter #(.FILT(RST_FILT)) u_filt (
    .clk(clk), .rst(rst), .lvl_n(rstn_s), .held_low(rst_low)
  );

  // reset pin is honoured only while the hold pin reads high
  assign rst_take = rst_low && hold_s;
  assign wake     = (state == PS_HOLD) && hold_s;
  assign cnt_clr  = rst_take || wake;

  hwc_stab_cnt #(.W(WAIT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr),
    .en(state == PS_STAB), .last(wait_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PS_STAB;
      osc_en     <= 1'b1;
      cpu_clk_en <= 1'b0;
      core_rst   <= 1'b1;
      tmr_preset <= 1'b0;
    end else begin
      tmr_preset <= 1'b0;
      if (rst_take) begin
        state      <= PS_STAB;
        osc_en     <= 1'b1;
        cpu_clk_en <= 1'b0;
        core_rst   <= 1'b1;
      end else begin
        unique case (state)
          PS_RUN: begin
            if (hold_req && !hold_s) begin
              state      <= PS_HOLD;
              osc_en     <= 1'b0;
              cpu_clk_en <= 1'b0;
            end
          end
          PS_HOLD: begin
            if (hold_s) begin
              state  <= PS_STAB;
              osc_en <= 1'b1;
            end
          end
          PS_STAB: begin
            if (wait_done) begin
              state      <= PS_RUN;
              cpu_clk_en <= 1'b1;
              core_rst   <= 1'b0;
              tmr_preset <= 1'b1;
            end
          end
          default: state <= PS_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/hold_wake_chk.sv
module hold_wake_chk #(
  parameter int WAIT_W = 14
) (
  input logic clk,
  input logic rst,
  input logic hold_req,
  input logic osc_en,
  input logic cpu_clk_en,
  input logic core_rst,
  input logic tmr_preset,
  input logic rst_take
);
  localparam logic [WAIT_W:0] WAIT_LEN = {1'b1, {WAIT_W{1'b0}}};

  logic [WAIT_W:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || rst_take || !osc_en) begin
      wcnt <= '0;
    end else if (!cpu_clk_en && wcnt != '1) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  AST_HOLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en) |-> $past(hold_req)); // R2

  AST_NO_CPU_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !cpu_clk_en); // R2

  AST_WAIT_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en) |-> (wcnt == WAIT_LEN)); // R5

  AST_PRESET_AT_START: assert property (@(posedge clk) disable iff (rst)
    tmr_preset |-> $rose(cpu_clk_en)); // R6

  AST_PRESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tmr_preset |=> !tmr_preset); // R6

  AST_RESET_STOPS_CPU: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> !cpu_clk_en); // R9
endmodule

bind hold_wake_ctrl hold_wake_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst(rst), .hold_req(hold_req), .osc_en(osc_en),
  .cpu_clk_en(cpu_clk_en), .core_rst(core_rst),
  .tmr_preset(tmr_preset), .rst_take(rst_take)
);

// File: tb/hold_wake_ctrl_test.sv
module hold_wake_ctrl_test;
  localparam int WW   = 6;
  localparam int WAIT = 1 << WW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_req = 1'b0;
  logic hold_pin = 1'b1;
  logic rst_pin_n = 1'b1;
  logic osc_en, cpu_clk_en, core_rst, tmr_preset;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hold_wake_ctrl #(.WAIT_W(WW), .SYNC_STAGES(2), .RST_FILT(3)) uut (
    .clk(clk), .rst(rst), .hold_req(hold_req), .hold_pin(hold_pin),
    .rst_pin_n(rst_pin_n), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .core_rst(core_rst), .tmr_preset(tmr_preset)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // idle in run state, verifying nothing moves
  task automatic idle_run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step();
      chk(cpu_clk_en && osc_en && !core_rst, req, {osc_en, cpu_clk_en, core_rst}, 3'b110);
    end
  endtask

  task automatic enter_hold();
    hold_pin = 1'b0;
    repeat (4) step();
    hold_req = 1'b1;
    step();
    hold_req = 1'b0;
    chk(!osc_en && !cpu_clk_en, "R2", {osc_en, cpu_clk_en}, 0);
  endtask

  initial begin
    int n;
    int first_rst;
    int first_cpu;
    // R1 reset state
    repeat (3) step();
    chk(core_rst && osc_en && !cpu_clk_en, "R1", {core_rst, osc_en, cpu_clk_en}, 3'b110);
    rst = 1'b0;
    n = 0;
    do begin step(); n++; end while (!cpu_clk_en && n < 1000);
    chk(n == WAIT, "R1", n, WAIT);
    chk(!core_rst, "R1", core_rst, 0);
    chk(tmr_preset, "R6", tmr_preset, 1);
    step();
    chk(!tmr_preset, "R6", tmr_preset, 0);

    // R3 request while hold pin high
    hold_req = 1'b1;
    step();
    hold_req = 1'b0;
    idle_run(10, "R3");

    // R2 hold entry, R7 reset ignored while held
    enter_hold();
    rst_pin_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step();
      chk(!core_rst && !osc_en, "R7", {core_rst, osc_en}, 0);
    end
    rst_pin_n = 1'b1;
    for (int i = 0; i < 14; i++) begin
      step();
      chk(!core_rst && !osc_en && !cpu_clk_en, "R2", {core_rst, osc_en, cpu_clk_en}, 0);
    end

    // R4 wake latency, R5 wait, R10 no reset, R6 preset
    hold_pin = 1'b1;
    n = 0;
    first_cpu = 0;
    while (first_cpu == 0 && n < 1000) begin
      step(); n++;
      if (n < 3) chk(!osc_en, "R4", osc_en, 0);
      if (n == 3) chk(osc_en, "R4", osc_en, 1);
      if (core_rst) chk(1'b0, "R10", core_rst, 0);
      if (cpu_clk_en) begin
        first_cpu = n;
        chk(tmr_preset, "R6", tmr_preset, 1);
      end
    end
    chk(first_cpu == 3 + WAIT, "R5", first_cpu, 3 + WAIT);

    // R7 reset ignored in run state with hold pin low
    hold_pin = 1'b0;
    repeat (4) step();
    rst_pin_n = 1'b0;
    idle_run(10, "R7");
    rst_pin_n = 1'b1;
    idle_run(6, "R7");
    hold_pin = 1'b1;
    idle_run(4, "R7");

    // R8 short pulses ignored
    for (int len = 1; len < 3; len++) begin
      rst_pin_n = 1'b0;
      repeat (len) step();
      rst_pin_n = 1'b1;
      idle_run(12, "R8");
    end

    // R8 accepted pulses, sweep of length
    for (int len = 3; len <= 8; len++) begin
      rst_pin_n = 1'b0;
      n = 0; first_rst = 0; first_cpu = 0;
      while (first_cpu == 0 && n < 1000) begin
        step(); n++;
        if (n == len) rst_pin_n = 1'b1;
        if (core_rst && first_rst == 0) begin
          first_rst = n;
          chk(!cpu_clk_en, "R8", cpu_clk_en, 0);
        end
        if (cpu_clk_en && first_rst != 0) first_cpu = n;
      end
      chk(first_rst == 6, "R8", first_rst, 6);
      chk(first_cpu == len + 3 + WAIT, "R8", first_cpu, len + 3 + WAIT);
      chk(!core_rst && tmr_preset, "R6", {core_rst, tmr_preset}, 1);
      idle_run(2, "R8");
    end

    // R9 reset in the middle of the wake wait
    for (int d = 5; d <= 55; d += 25) begin
      enter_hold();
      repeat (6) step();
      hold_pin = 1'b1;
      repeat (3 + d) step();
      rst_pin_n = 1'b0;
      n = 0; first_cpu = 0;
      while (first_cpu == 0 && n < 1000) begin
        step(); n++;
        if (n == 3) rst_pin_n = 1'b1;
        if (n == 6) chk(core_rst, "R9", core_rst, 1);
        if (cpu_clk_en) first_cpu = n;
      end
      chk(first_cpu == 6 + WAIT, "R9", first_cpu, 6 + WAIT);
      idle_run(2, "R9");
    end

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule